// File: doc/BRIEF.md
# Half-Word Parity Storage Module

This block is one word-addressed storage module that sits behind a request/acknowledge handshake. A requester presents a module-select code, a word address, a write strobe and, for writes, a 36-bit data word. The module answers only when the select code matches its own identity. It then runs a fixed-length cycle and closes it with a one-clock acknowledge.

Each stored word carries two parity bits that cannot be addressed. One bit covers the upper half-word and the other covers the lower half-word, and each half uses odd parity. The module generates parity on every write. On a read, the word is first moved destructively into a data register, with the array location cleared, and is then restored during the same cycle. Parity is checked on the way out, and a mismatch raises a one-clock parity-error pulse alongside the acknowledge. The restore writes back the word exactly as it was read, bad parity included, so a fault is seen again on every later read until the word is rewritten. Two test inputs flip either parity bit during a write so that faults can be injected.

The default array depth is reduced (`ADDR_W` = 10). Setting `ADDR_W` to 15 gives the full 32,768-word module.

Top module: `parity_store`

## Requirements
- R1: After reset `ack_o` and `perr_o` are low and the module is idle, ready to accept a request.
- R2: A request whose `bank_i` differs from `MOD_ID` is ignored: no acknowledge, no busy period, and no change to any stored word.
- R3: A request is accepted on a clock edge where the module is idle and selected. `ack_o` is then high for exactly one clock, starting CYC edges after the accepting edge.
- R4: A write stores `wdata_i` at `addr_i`. A later read of that address returns the same 36 bits on `rdata_o` in the acknowledge cycle.
- R5: Parity is odd per half-word. Bit 37 makes bits 35..18 plus itself an odd count of ones, and bit 36 does the same for bits 17..0. A word written without injection reads back with `perr_o` low.
- R6: A write with `flip_hi_i` or `flip_lo_i` high inverts the upper or lower parity bit respectively. A read of that word raises `perr_o` in the same cycle as `ack_o`, and the data bits are still returned intact.
- R7: After a read that found bad parity, the word is restored with its bad parity, so the next read of the same address raises `perr_o` again with the same data.
- R8: A request that arrives while a cycle is in progress is ignored: it produces no extra acknowledge and does not alter memory.
- R9: `perr_o` is only ever high together with `ack_o` at the end of a read; a write never raises it.
- R10: Rewriting a faulty word without injection clears the fault, so the next read shows `perr_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| bank_i | input | 3 | Module-select code from the system address |
| addr_i | input | ADDR_W | Word address within the module |
| wdata_i | input | 36 | Write data |
| flip_hi_i | input | 1 | Test: invert the upper-half parity bit on a write |
| flip_lo_i | input | 1 | Test: invert the lower-half parity bit on a write |
| rdata_o | output | 36 | Read data, valid in the acknowledge cycle of a read |
| ack_o | output | 1 | One-clock acknowledge closing each reference |
| perr_o | output | 1 | One-clock parity-error interrupt to the served requester |

## Verification
The acknowledge and the parity-error interrupt both fall in the closing cycle of a faulty read. The bench provokes this by writing words with one parity bit inverted through either flip input and then reading them. It samples both outputs on the same clock, so the pair must rise together. A second coincidence arises when a new request overlaps a cycle already in progress. The bench holds a foreign write on the inputs during the busy window and judges the outcome by counting acknowledges and reading the targeted word back unchanged.

// File: rtl/parity_store.sv
module parity_store #(
  parameter int ADDR_W = 10,
  parameter int DW     = 36,
  parameter int CYC    = 4,
  parameter int MOD_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [2:0]        bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              flip_hi_i,
  input  logic              flip_lo_i,
  output logic [DW-1:0]     rdata_o,
  output logic              ack_o,
  output logic              perr_o
);
  localparam int HW    = DW / 2;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = $clog2(CYC + 1);

  logic [DW+1:0]     mem [DEPTH];
  logic [DW+1:0]     dreg;
  logic              busy, wr_q;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] addr_q;

  wire hit   = req_i && (bank_i == 3'(MOD_ID)) && !busy;
  wire last  = busy && (cnt == CW'(CYC - 1));
  wire fetch = busy && (cnt == '0) && !wr_q;

  wire p_hi = ~(^wdata_i[DW-1:HW]) ^ flip_hi_i;
  wire p_lo = ~(^wdata_i[HW-1:0])  ^ flip_lo_i;
  wire bad  = !(^{dreg[DW+1], dreg[DW-1:HW]}) || !(^{dreg[DW], dreg[HW-1:0]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      ack_o   <= 1'b0;
      perr_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o  <= last;
      perr_o <= last && !wr_q && bad;
      if (last && !wr_q) rdata_o <= dreg[DW-1:0];
      if (hit) begin
        busy   <= 1'b1;
        cnt    <= '0;
        wr_q   <= wr_i;
        addr_q <= addr_i;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (last) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (hit && wr_i) dreg <= {p_hi, p_lo, wdata_i};
    else if (fetch) begin
      dreg         <= mem[addr_q];
      mem[addr_q]  <= '0;
    end
    if (last) mem[addr_q] <= dreg;
  end
endmodule

// File: rtl/parity_store_chk.sv
module parity_store_chk #(
  parameter int CYC    = 4,
  parameter int MOD_ID = 0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_i,
  input logic [2:0] bank_i,
  input logic       busy,
  input logic       wr_q,
  input logic       ack_o,
  input logic       perr_o
);
  int unsigned ctr;
  wire take = req_i && (bank_i == 3'(MOD_ID)) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ctr <= 0;
    else if (take)       ctr <= 1;
    else if (ack_o)      ctr <= 0;
    else if (ctr != 0)   ctr <= ctr + 1;
  end

  // R3
  ack_one_chk: assert property (@(posedge clk) disable iff (!rst_n) ack_o |=> !ack_o);
  // R3
  ack_time_chk: assert property (@(posedge clk) disable iff (!rst_n) ack_o |-> (ctr == CYC + 1));
  // R9
  perr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n) perr_o |-> (ack_o && !wr_q));
  // R2
  foreign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_i && bank_i != 3'(MOD_ID)) |=> !busy);
  // R1
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n) (ctr == 0) |-> !ack_o);
endmodule

bind parity_store parity_store_chk #(.CYC(CYC), .MOD_ID(MOD_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .bank_i(bank_i),
  .busy(busy), .wr_q(wr_q), .ack_o(ack_o), .perr_o(perr_o));

// File: tb/parity_store_bench.sv
`timescale 1ns/1ps
module parity_store_bench;
  localparam int AW  = 10;
  localparam int CYC = 4;
  localparam int MID = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, wr = 0, fh = 0, fl = 0;
  logic [2:0] bank = 0;
  logic [AW-1:0] addr = 0;
  logic [35:0] wd = 0, rd;
  logic ack, pe;
  int runs = 0, fails = 0;

  always #2 clk = ~clk;

  parity_store #(.ADDR_W(AW), .CYC(CYC), .MOD_ID(MID)) u_parity_store (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .bank_i(bank), .addr_i(addr),
    .wdata_i(wd), .flip_hi_i(fh), .flip_lo_i(fl), .rdata_o(rd), .ack_o(ack), .perr_o(pe));

  typedef struct packed {
    logic wr; logic [2:0] bank; logic [AW-1:0] addr; logic [35:0] d;
    logic fh; logic fl; logic eack; logic [35:0] erd; logic epe;
  } vec_t;

  localparam vec_t VT [15] = '{
    '{1'b1, 3'd5, 10'd3,    36'h123456789, 1'b0, 1'b0, 1'b1, 36'h0,          1'b0},
    '{1'b0, 3'd5, 10'd3,    36'h0,         1'b0, 1'b0, 1'b1, 36'h123456789,  1'b0},
    '{1'b1, 3'd5, 10'd1023, 36'hFFFFFFFFF, 1'b0, 1'b0, 1'b1, 36'h0,          1'b0},
    '{1'b0, 3'd5, 10'd1023, 36'h0,         1'b0, 1'b0, 1'b1, 36'hFFFFFFFFF,  1'b0},
    '{1'b1, 3'd5, 10'd0,    36'h000000000, 1'b0, 1'b0, 1'b1, 36'h0,          1'b0},
    '{1'b0, 3'd5, 10'd0,    36'h0,         1'b0, 1'b0, 1'b1, 36'h000000000,  1'b0},
    '{1'b1, 3'd2, 10'd3,    36'hAAAAAAAAA, 1'b0, 1'b0, 1'b0, 36'h0,          1'b0},
    '{1'b0, 3'd5, 10'd3,    36'h0,         1'b0, 1'b0, 1'b1, 36'h123456789,  1'b0},
    '{1'b1, 3'd5, 10'd7,    36'h0F0F0F0F0, 1'b1, 1'b0, 1'b1, 36'h0,          1'b0},
    '{1'b0, 3'd5, 10'd7,    36'h0,         1'b0, 1'b0, 1'b1, 36'h0F0F0F0F0,  1'b1},
    '{1'b0, 3'd5, 10'd7,    36'h0,         1'b0, 1'b0, 1'b1, 36'h0F0F0F0F0,  1'b1},
    '{1'b1, 3'd5, 10'd8,    36'h555555555, 1'b0, 1'b1, 1'b1, 36'h0,          1'b0},
    '{1'b0, 3'd5, 10'd8,    36'h0,         1'b0, 1'b0, 1'b1, 36'h555555555,  1'b1},
    '{1'b1, 3'd5, 10'd7,    36'h000000001, 1'b0, 1'b0, 1'b1, 36'h0,          1'b0},
    '{1'b0, 3'd5, 10'd7,    36'h0,         1'b0, 1'b0, 1'b1, 36'h000000001,  1'b0}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one access; returns edge index of the ack (0 = none), data and error seen with it
  task automatic access(input logic w, input logic [2:0] b, input logic [AW-1:0] a,
                        input logic [35:0] d, input logic h, input logic l,
                        output int at, output int nack, output logic [35:0] r, output logic e);
    at = 0; nack = 0; r = '0; e = 1'b0;
    @(negedge clk);
    req = 1; wr = w; bank = b; addr = a; wd = d; fh = h; fl = l;
    @(negedge clk);
    req = 0; fh = 0; fl = 0;
    for (int i = 1; i <= CYC + 2; i++) begin
      @(negedge clk);
      if (ack) begin
        nack++;
        if (at == 0) begin at = i; r = rd; e = pe; end
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    int at, nk;
    logic [35:0] r;
    logic e;
    repeat (3) @(negedge clk);
    chk(ack == 0, "R1 ack after reset", 64'(ack), 0);
    chk(pe == 0, "R1 perr after reset", 64'(pe), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(ack == 0 && pe == 0, "R1 idle outputs", 64'({ack, pe}), 0);

    for (int i = 0; i < 15; i++) begin
      access(VT[i].wr, VT[i].bank, VT[i].addr, VT[i].d, VT[i].fh, VT[i].fl, at, nk, r, e);
      if (VT[i].eack) begin
        chk(at == CYC && nk == 1, "R3 ack timing", 64'(at), 64'(CYC));
        if (!VT[i].wr) begin
          chk(r == VT[i].erd, "R4 read data", 64'(r), 64'(VT[i].erd));
          chk(e == VT[i].epe, VT[i].epe ? "R6 R7 parity error with ack" : "R5 R10 clean parity",
              64'(e), 64'(VT[i].epe));
        end else
          chk(e == 0, "R9 write raises no error", 64'(e), 0);
      end else
        chk(nk == 0, "R2 foreign bank no ack", 64'(nk), 0);
    end

    // R8: overlapping request during a busy cycle
    access(1'b1, 3'(MID), 10'd21, 36'h0000ABCDE, 0, 0, at, nk, r, e);
    @(negedge clk);
    req = 1; wr = 1; bank = 3'(MID); addr = 10'd20; wd = 36'h111111111;
    @(negedge clk);
    wr = 1; addr = 10'd21; wd = 36'h999999999;
    nk = 0;
    for (int i = 1; i < CYC; i++) begin
      @(negedge clk);
      if (ack) nk++;
    end
    req = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (ack) nk++;
    end
    chk(nk == 1, "R8 single ack under overlap", 64'(nk), 1);
    access(1'b0, 3'(MID), 10'd21, 36'h0, 0, 0, at, nk, r, e);
    chk(r == 36'h0000ABCDE, "R8 overlapped write ignored", 64'(r), 64'h0000ABCDE);
    access(1'b0, 3'(MID), 10'd20, 36'h0, 0, 0, at, nk, r, e);
    chk(r == 36'h111111111 && e == 0, "R4 accepted write kept", 64'(r), 64'h111111111);

    // R6: error pulse and ack on the same sample, lower-half flip on an odd-weight word
    access(1'b1, 3'(MID), 10'd30, 36'h000000001, 0, 1, at, nk, r, e);
    access(1'b0, 3'(MID), 10'd30, 36'h0, 0, 0, at, nk, r, e);
    chk(at == CYC && e == 1, "R6 error coincides with ack", 64'(e), 1);
    chk(r == 36'h000000001, "R6 data intact", 64'(r), 64'h1);
    @(negedge clk);
    chk(pe == 0 && ack == 0, "R9 error is one clock", 64'({ack, pe}), 0);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule